// File: doc/BRIEF.md
# Gated Prescaled 16-bit Timer

This block is a 16-bit up-counting timer with a small register port. Each count step comes from one of two sources: an internal tick that fires once every two system clocks, or rising edges seen on an external clock pin. That tick then passes through a prescaler that divides by 1, 8, 64 or 256. With the internal source selected, a gated accumulation mode lets the counter advance only while an external gate input is high. A falling edge of the gate then raises the interrupt flag. In the normal mode the counter wraps to zero when it matches a period register, and the flag is raised on that wrap.

Software writes and reads a control word, the count and the period through a small address-decoded port. The count and period can also be written directly. The interrupt flag stays set until software clears it. Two inputs can freeze the count. An idle request does so when the stop-in-idle bit is set. A 32-bit pairing input makes the timer behave as the slave half of a wider timer, and while it is high this timer does not advance on its own. The external clock and gate pins are asynchronous and pass through two synchronizing flops before they are used.

Top module: `gtimer16`

## Requirements
- R1: Address 0 holds the control word: run enable at bit 15, stop-in-idle at bit 13, gate enable at bit 6, prescale select at bits 5:4 and clock source at bit 1. All other bits read as zero, so writing 16'hFFFF reads back 16'hA072. After reset the control word and the count read 0, the period (address 2) reads 16'hFFFF, and the flag (address 3, bit 0) reads 0.
- R2: With the clock source bit at 0, the counter advances by exactly one for every 2×N system clocks, where N is the prescale ratio.
- R3: Prescale select 00, 01, 10 and 11 give the ratios 1, 8, 64 and 256. Any write to the control word restarts the prescaler without changing the count.
- R4: With the clock source bit at 1, each rising edge on ext_clk is one prescaler input. After N×k edges counted from a control write, the count has advanced by exactly k.
- R5: In non-gated mode, a step taken while the count equals the period loads 0 instead and sets the flag, so the count cycles through 0..period.
- R6: With gate enable at 1 and the internal source selected, the counter advances only while gate_in is high, and there is no period match. A falling edge of gate_in sets the flag.
- R7: With the clock source bit at 1, gate enable is ignored. Edges on ext_clk are counted even while gate_in is low.
- R8: With stop-in-idle at 1, the count holds while idle_req is high. With stop-in-idle at 0, idle_req has no effect.
- R9: The count holds while run enable is 0 or while pair32 is high. The control bits can still be written and read back during that time.
- R10: The flag stays set until any write to address 3 clears it. If a set and a clear fall in the same cycle, the set wins. Writes to address 1 load the count and writes to address 2 load the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 count, 2 period, 3 flag clear |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as write |
| rd_data | output | 16 | Read data (combinational) |
| ext_clk | input | 1 | Asynchronous external clock pin |
| gate_in | input | 1 | Asynchronous gate pin |
| idle_req | input | 1 | Idle-mode request |
| pair32 | input | 1 | Pairing as slave half of a 32-bit timer |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The hardest case to reach is the exact step rate under the largest prescaler, because the phase of the internal half-rate tick and the state of the prescaler cannot be seen at the ports. The stimulus avoids depending on either. Each measurement starts well after a control write and then reads the count across an interval that is a whole number of prescaler periods, so the expected change is exactly k whatever the phase. External-clock runs count from a control write, which restarts the prescaler, and use pulses wide enough to pass the synchronizer. Gated mode is driven by holding gate_in high across a measured window and then dropping it to produce the flag.

// File: rtl/gtimer16.sv
module gtimer16 #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          ext_clk,
  input  logic          gate_in,
  input  logic          idle_req,
  input  logic          pair32,
  output logic          irq_flag
);
  localparam int PW = 8;

  logic          run_en, sidl, gate_en, src_ext;
  logic [1:0]    psel;
  logic [CW-1:0] cnt_q, per_q;
  logic [PW-1:0] pre_q, pre_lim;
  logic          phase_q, flag_q;
  logic [2:0]    ext_s, gate_s;

  wire wr_ctrl = wr_en && wr_addr == 2'd0;
  wire wr_cnt  = wr_en && wr_addr == 2'd1;
  wire wr_per  = wr_en && wr_addr == 2'd2;
  wire wr_clr  = wr_en && wr_addr == 2'd3;

  wire gmode     = gate_en & ~src_ext;
  wire active    = run_en & ~pair32;
  wire running   = active & ~(sidl & idle_req);
  wire ext_rise  = ext_s[1] & ~ext_s[2];
  wire gate_lvl  = gate_s[1];
  wire gate_fall = gate_s[2] & ~gate_s[1];
  wire src_tick  = src_ext ? ext_rise : phase_q;
  wire raw_tick  = running & src_tick & (~gmode | gate_lvl);
  wire pre_hit   = raw_tick && pre_q == pre_lim;
  wire match     = pre_hit & ~gmode & (cnt_q == per_q);
  wire gate_irq  = gmode & active & gate_fall;

  always_comb begin
    case (psel)
      2'd0:    pre_lim = 8'd0;
      2'd1:    pre_lim = 8'd7;
      2'd2:    pre_lim = 8'd63;
      default: pre_lim = 8'd255;
    endcase
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {run_en, 1'b0, sidl, 6'b0, gate_en, psel, 2'b0, src_ext, 1'b0};
      2'd1:    rd_data = cnt_q;
      2'd2:    rd_data = per_q;
      default: rd_data = {{(CW-1){1'b0}}, flag_q};
    endcase
  end

  assign irq_flag = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {run_en, sidl, gate_en, psel, src_ext} <= '0;
      phase_q <= 1'b0;
      ext_s   <= '0;
      gate_s  <= '0;
    end else begin
      phase_q <= ~phase_q;
      ext_s   <= {ext_s[1:0], ext_clk};
      gate_s  <= {gate_s[1:0], gate_in};
      if (wr_ctrl) begin
        run_en  <= wr_data[15];
        sidl    <= wr_data[13];
        gate_en <= wr_data[6];
        psel    <= wr_data[5:4];
        src_ext <= wr_data[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pre_q <= '0;
    else if (wr_ctrl || !run_en) pre_q <= '0;
    else if (pre_hit)           pre_q <= '0;
    else if (raw_tick)          pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      if (wr_cnt)       cnt_q <= wr_data;
      else if (pre_hit) cnt_q <= match ? '0 : cnt_q + 1'b1;
      if (wr_per) per_q <= wr_data;
      if (match || gate_irq) flag_q <= 1'b1;
      else if (wr_clr)       flag_q <= 1'b0;
    end
  end
endmodule

module gtimer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [1:0]  rd_addr,
  input logic [15:0] rd_data,
  input logic [15:0] cnt,
  input logic        flag,
  input logic        run_en,
  input logic        sidl,
  input logic        idle_req,
  input logic        pair32,
  input logic        gmode
);
  wire cnt_wr = wr_en && wr_addr == 2'd1;

  assert_ctrl_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 2'd0 |-> (rd_data & 16'h5F8D) == 16'h0);

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1 || cnt == 16'd0));

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !gmode && !cnt_wr) |=> (!flag || cnt == 16'd0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sidl && idle_req && !cnt_wr) |=> $stable(cnt));

  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!run_en || pair32) && !cnt_wr) |=> $stable(cnt));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && wr_addr == 2'd3)) |=> flag);
endmodule

bind gtimer16 gtimer16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt_q), .flag(flag_q),
  .run_en(run_en), .sidl(sidl), .idle_req(idle_req), .pair32(pair32),
  .gmode(gmode)
);

// File: tb/gtimer16_tb.sv
module gtimer16_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic ext_clk = 0, gate_in = 0, idle_req = 0, pair32 = 0;
  logic irq_flag;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gtimer16 u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk(ext_clk),
    .gate_in(gate_in), .idle_req(idle_req), .pair32(pair32), .irq_flag(irq_flag));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n);
    repeat (n) begin
      ext_clk = 1; clocks(4); ext_clk = 0; clocks(4);
    end
    clocks(4);
  endtask

  task automatic delta(int span, output int d);
    int a, b;
    rd(2'd1, a); clocks(span); rd(2'd1, b);
    d = (b - a) & 16'hFFFF;
  endtask

  initial begin
    int v, d, prev, bad;
    int ratio [4] = '{1, 8, 64, 256};
    clocks(3); rst_n = 1; clocks(1);
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl reset", v, 0);
    rd(2'd1, v); check("R1 count reset", v, 0);
    rd(2'd2, v); check("R1 period reset", v, 16'hFFFF);
    rd(2'd3, v); check("R1 flag reset", v, 0);
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R1 ctrl mask", v, 16'hA072);
    wr(2'd0, 16'h0000); rd(2'd0, v); check("R1 ctrl clear", v, 0);

    // R2 R3 internal source, all prescale codes
    for (int p = 0; p < 4; p++) begin
      wr(2'd0, 16'h8000 | (p << 4));
      clocks(20);
      delta(2 * ratio[p] * 4, d);
      check($sformatf("R2 R3 internal prescale code %0d", p), d, 4);
    end

    // R3 control write restarts prescaler, count kept
    wr(2'd0, 16'h0000); wr(2'd1, 16'd77);
    wr(2'd0, 16'h0030); rd(2'd1, v); check("R3 ctrl write keeps count", v, 77);

    // R4 external source, all prescale codes
    for (int p = 0; p < 4; p++) begin
      wr(2'd0, 16'h8002 | (p << 4)); wr(2'd1, 16'd0);
      pulses(ratio[p] * 3);
      rd(2'd1, v); check($sformatf("R4 external prescale code %0d", p), v, 3);
    end

    // R7 gate ignored with external source
    wr(2'd0, 16'h8042); wr(2'd1, 16'd0); gate_in = 0;
    pulses(5); rd(2'd1, v); check("R7 gate ignored external", v, 5);

    // R10 count/period write, flag clear
    wr(2'd0, 16'h0000); wr(2'd2, 16'd5); rd(2'd2, v); check("R10 period write", v, 5);
    wr(2'd1, 16'd0); wr(2'd3, 16'd0);

    // R5 period wrap sweep
    wr(2'd0, 16'h8000); clocks(20);
    rd(2'd3, v); check("R5 flag set on match", v, 1);
    rd(2'd1, prev); bad = 0;
    for (int i = 0; i < 24; i++) begin
      clocks(2); rd(2'd1, v);
      if (v != (prev + 1) % 6) bad++;
      if (v > 5) bad++;
      prev = v;
    end
    check("R5 count cycles 0..period", bad, 0);

    // R10 sticky flag and clear
    wr(2'd0, 16'h0000); clocks(10);
    rd(2'd3, v); check("R10 flag sticky", v, 1);
    wr(2'd3, 16'd0); rd(2'd3, v); check("R10 flag cleared", v, 0);

    // R6 gated accumulation
    wr(2'd2, 16'd3); wr(2'd1, 16'd0); gate_in = 0;
    wr(2'd0, 16'h8040); clocks(40);
    rd(2'd1, v); check("R6 gate low holds", v, 0);
    gate_in = 1; clocks(8);
    delta(20, d); check("R6 gate high counts", d, 10);
    rd(2'd1, v); check("R6 no period match", (v > 3) ? 1 : 0, 1);
    rd(2'd3, v); check("R6 flag clear while high", v, 0);
    gate_in = 0; clocks(8);
    rd(2'd3, v); check("R6 gate fall sets flag", v, 1);
    delta(20, d); check("R6 hold after fall", d, 0);
    wr(2'd3, 16'd0); wr(2'd2, 16'hFFFF);

    // R8 stop in idle
    wr(2'd0, 16'hA000); idle_req = 1; clocks(10);
    delta(40, d); check("R8 idle stops", d, 0);
    idle_req = 0; clocks(4);
    delta(16, d); check("R8 idle released", d, 8);
    wr(2'd0, 16'h8000); idle_req = 1; clocks(10);
    delta(16, d); check("R8 idle ignored", d, 8);
    idle_req = 0;

    // R9 run disable and pairing
    wr(2'd0, 16'h0000); clocks(4);
    delta(40, d); check("R9 run off holds", d, 0);
    wr(2'd0, 16'h8000); pair32 = 1; clocks(4);
    delta(40, d); check("R9 pair holds", d, 0);
    wr(2'd0, 16'h8032); rd(2'd0, v); check("R9 ctrl writable paired", v, 16'h8032);
    wr(2'd0, 16'h8000); pair32 = 0; clocks(10);
    delta(16, d); check("R9 unpaired counts", d, 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R2 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule